// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status word that a parallel NOR flash places on its data bus when the host reads it while an automatic program or erase algorithm is running. The host polls the part with ordinary read cycles. Each read returns a "data-not" bit, two toggle bits, a failure bit and an erase-start bit. The host uses these bits to learn whether the operation is still running, whether an erase is suspended, which sectors are part of the erase, and whether the operation failed.

The surrounding flash model supplies the context. It provides a one-cycle start pulse with the operation kind when the final write strobe of a command sequence completes. It also supplies the erase sector selection, the protection map, the data bit being programmed, a flag for an illegal 0-to-1 program, a tick per internal program/erase pulse with the pulse limit, a done pulse from the algorithm, a suspend level, and a read/reset command pulse. The block tracks the operation's phase and timers. It returns to array-read mode, where it stops driving status, when the operation ends.

Top module: `flst_status_gen`

## Requirements
- R1: After reset, and whenever no operation is running, `status_drive` is 0 and `status_q` is 0, including during read cycles.
- R2: A read cycle begins when both `rd_ce_n` and `rd_oe_n` are low after at least one of them was high. While an operation runs and is not suspended, each read cycle begins by inverting bit 6. Bit 6 holds while a read is held low. Bit 6 and bit 2 start at 0 when an operation is accepted.
- R3: While an erase is suspended (`erase_susp` high during the erase phase), bit 6 holds across reads, bit 7 reads 1, and pulse ticks and done pulses are ignored.
- R4: For erase operations, bit 2 inverts at the start of each read whose sector index (the top `SECT_BITS` address bits) is a selected sector. This holds whether the erase is active or suspended. Bit 2 holds for reads of other sectors and stays 0 for programs.
- R5: `cmd_op` encodes 0 program, 1 sector erase, 2 chip erase, and 3 no command. While running, bit 7 is the complement of the latched program data bit for a program, and 0 for an erase. A done pulse ends the operation and returns the block to array-read mode.
- R6: After a sector erase start, bit 3 reads 0 for ARM_US*CYC_PER_US cycles and then reads 1. For a chip erase, bit 3 reads 1 at once. Bit 3 reads 0 for a program.
- R7: If every sector selected by an erase is protected (chip erase selects all sectors), the block reports a running erase with bit 3 at 1. It stays in that state for PROT_US*CYC_PER_US cycles and then returns to array-read mode on its own.
- R8: When the number of pulse ticks during a running operation reaches `pulse_limit`, bit 5 becomes 1. Status mode then persists, ignoring done pulses, until `rst_cmd`.
- R9: A program started with `prog_zero_to_one` high fails at once, with bit 5 at 1.
- R10: Bits 4, 1 and 0 always read 0, and bit 5 reads 0 unless a failure occurred.
- R11: `rst_cmd` returns a failed operation to array-read mode and has no effect while an operation is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Operation start pulse (end of command sequence) |
| cmd_op | input | 2 | Operation kind: 0 program, 1 sector erase, 2 chip erase |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| prog_zero_to_one | input | 1 | Program attempts to set a stored 0 to 1 |
| sect_sel | input | NUM_SECT | Sectors selected for a sector erase |
| sect_prot | input | NUM_SECT | Sector protection map |
| pulse_tick | input | 1 | One internal program/erase pulse issued |
| pulse_limit | input | PCNT_W | Maximum pulse count before failure |
| alg_done | input | 1 | Algorithm finished successfully |
| erase_susp | input | 1 | Erase suspend level |
| rst_cmd | input | 1 | Read/reset command pulse |
| rd_ce_n | input | 1 | Chip enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address |
| status_drive | output | 1 | Status word is driven on the bus |
| status_q | output | 8 | Status word |

## Verification
A phase register stuck in the wrong state shows up within one read cycle. `status_drive` stays high after an operation has ended, or bit 3 or bit 5 has the wrong value. A toggle register that flips at the wrong time, or fails to flip, appears at the next read start as a bit-6 or bit-2 mismatch. The bench therefore polls after every stimulus. A timer that is off by one cycle becomes visible at the exact cycle where the erase window or the protected-sector window closes. The bench reads just before and just after each of those edges.

// File: rtl/flst_pkg.sv
// Shared types for the flash status generator.
package flst_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } flst_op_e;

    typedef enum logic [2:0] {
        ST_ARRAY = 3'd0,
        ST_ARM   = 3'd1,
        ST_ALGO  = 3'd2,
        ST_PROT  = 3'd3,
        ST_FAIL  = 3'd4
    } flst_st_e;
endpackage

// File: rtl/flst_win_timer.sv
// Window timer: restarts on start, and while run is high counts cycles.
// expire is high during the cycle in which LIMIT cycles have elapsed.
// Assumes LIMIT >= 1.
module flst_win_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count elapsed cycles of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/flst_sect_hit.sv
// Sector hit decode: flags a read address whose sector index (top
// SECT_BITS bits) belongs to the latched selection map.
module flst_sect_hit #(
    parameter int ADDR_W    = 16,
    parameter int SECT_BITS = 2,
    localparam int NUM_SECT = 1 << SECT_BITS
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_SECT-1:0] sel,
    output logic                hit
);
    logic [SECT_BITS-1:0] idx;
    logic [NUM_SECT-1:0]  hit_vec;

    assign idx = rd_addr[ADDR_W-1 -: SECT_BITS];

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        assign hit_vec[i] = sel[i] && (idx == SECT_BITS'(i));
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/flst_ctrl.sv
// Operation phase controller. Accepts a start in array mode, latches the
// operation context, runs the erase-start and protected-sector windows,
// counts pulses against the limit and holds failure until read/reset.
// Assumes cmd_go is a single-cycle pulse.
module flst_ctrl
    import flst_pkg::*;
#(
    parameter int SECT_BITS = 2,
    parameter int CYC_PER_US = 50,
    parameter int PROT_US = 100,
    parameter int ARM_US = 50,
    parameter int PCNT_W = 12,
    localparam int NUM_SECT = 1 << SECT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_go,
    input  logic [1:0]          cmd_op,
    input  logic                prog_d7,
    input  logic                prog_zero_to_one,
    input  logic [NUM_SECT-1:0] sect_sel,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                pulse_tick,
    input  logic [PCNT_W-1:0]   pulse_limit,
    input  logic                alg_done,
    input  logic                erase_susp,
    input  logic                rst_cmd,
    output flst_st_e            st,
    output flst_op_e            op_l,
    output logic                d7_l,
    output logic [NUM_SECT-1:0] sel_l,
    output logic                accept,
    output logic                susp
);
    localparam int PROT_CYC = PROT_US * CYC_PER_US;
    localparam int ARM_CYC  = ARM_US * CYC_PER_US;

    flst_op_e            op_in;
    flst_st_e            st_nx;
    logic [NUM_SECT-1:0] sel_eff;
    logic                all_prot;
    logic                arm_exp;
    logic                prot_exp;
    logic [PCNT_W-1:0]   pcnt;
    logic                limit_hit;
    logic                run_active;

    assign op_in    = flst_op_e'(cmd_op);
    assign accept   = cmd_go && (st == ST_ARRAY) && (op_in != OP_NONE);
    assign sel_eff  = (op_in == OP_CHIP) ? '1 : sect_sel;
    assign all_prot = ((sel_eff & ~sect_prot) == '0);
    assign susp     = erase_susp && (st == ST_ALGO) && (op_l != OP_PROG);
    assign run_active = (st == ST_ALGO) && !susp;
    assign limit_hit  = pulse_tick &&
                        ({1'b0, pcnt} + 1'b1 >= {1'b0, pulse_limit});

    flst_win_timer #(.LIMIT(ARM_CYC)) u_arm_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .run    (st == ST_ARM),
        .expire (arm_exp)
    );

    flst_win_timer #(.LIMIT(PROT_CYC)) u_prot_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .run    (st == ST_PROT),
        .expire (prot_exp)
    );

    // Next phase selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARRAY: begin
                if (accept) begin
                    if (op_in == OP_PROG) begin
                        st_nx = prog_zero_to_one ? ST_FAIL : ST_ALGO;
                    end else if (all_prot) begin
                        st_nx = ST_PROT;
                    end else begin
                        st_nx = (op_in == OP_SECT) ? ST_ARM : ST_ALGO;
                    end
                end
            end
            ST_ARM:  if (arm_exp) st_nx = ST_ALGO;
            ST_ALGO: begin
                if (run_active) begin
                    if (limit_hit)     st_nx = ST_FAIL;
                    else if (alg_done) st_nx = ST_ARRAY;
                end
            end
            ST_PROT: if (prot_exp) st_nx = ST_ARRAY;
            ST_FAIL: if (rst_cmd) st_nx = ST_ARRAY;
            default: st_nx = ST_ARRAY;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_ARRAY;
        else        st <= st_nx;
    end

    // Latch the operation context at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_l  <= OP_PROG;
            d7_l  <= 1'b0;
            sel_l <= '0;
        end else if (accept) begin
            op_l  <= op_in;
            d7_l  <= prog_d7;
            sel_l <= (op_in == OP_PROG) ? '0 : sel_eff;
        end
    end

    // Pulse counter for the exceeded-limit check.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            pcnt <= '0;
        end else if (run_active && pulse_tick && !limit_hit) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/flst_toggle.sv
// Read-cycle detector and toggle registers. A read cycle starts when both
// strobes go active. Bit 6 flips per read start unless suspended; bit 2
// flips per read start into a selected sector. Both clear on acceptance.
module flst_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_ce_n,
    input  logic rd_oe_n,
    input  logic status_mode,
    input  logic accept,
    input  logic susp,
    input  logic hit,
    output logic rd_act,
    output logic rd_start,
    output logic tog6,
    output logic tog2
);
    logic rd_act_q;

    assign rd_act   = !rd_ce_n && !rd_oe_n;
    assign rd_start = rd_act && !rd_act_q;

    // Remember the previous strobe state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_act_q <= 1'b0;
        else        rd_act_q <= rd_act;
    end

    // Toggle bit updates per read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else if (rd_start && status_mode) begin
            if (!susp) tog6 <= ~tog6;
            if (hit)   tog2 <= ~tog2;
        end
    end
endmodule

// File: rtl/flst_status_gen.sv
// Status word generator top. Combines the phase controller, sector decode
// and toggle registers into the polled status byte and its drive enable.
// Assumes the read address is stable while the strobes are active.
module flst_status_gen
    import flst_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SECT_BITS  = 2,
    parameter int CYC_PER_US = 50,
    parameter int PROT_US    = 100,
    parameter int ARM_US     = 50,
    parameter int PCNT_W     = 12,
    localparam int NUM_SECT  = 1 << SECT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_go,
    input  logic [1:0]          cmd_op,
    input  logic                prog_d7,
    input  logic                prog_zero_to_one,
    input  logic [NUM_SECT-1:0] sect_sel,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                pulse_tick,
    input  logic [PCNT_W-1:0]   pulse_limit,
    input  logic                alg_done,
    input  logic                erase_susp,
    input  logic                rst_cmd,
    input  logic                rd_ce_n,
    input  logic                rd_oe_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                status_drive,
    output logic [7:0]          status_q
);
    flst_st_e            st;
    flst_op_e            op_l;
    logic                d7_l;
    logic [NUM_SECT-1:0] sel_l;
    logic                accept;
    logic                susp;
    logic                hit;
    logic                rd_act;
    logic                rd_start;
    logic                tog6;
    logic                tog2;
    logic                status_mode;
    logic                is_prog;
    logic [7:0]          word;

    flst_ctrl #(
        .SECT_BITS  (SECT_BITS),
        .CYC_PER_US (CYC_PER_US),
        .PROT_US    (PROT_US),
        .ARM_US     (ARM_US),
        .PCNT_W     (PCNT_W)
    ) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_go           (cmd_go),
        .cmd_op           (cmd_op),
        .prog_d7          (prog_d7),
        .prog_zero_to_one (prog_zero_to_one),
        .sect_sel         (sect_sel),
        .sect_prot        (sect_prot),
        .pulse_tick       (pulse_tick),
        .pulse_limit      (pulse_limit),
        .alg_done         (alg_done),
        .erase_susp       (erase_susp),
        .rst_cmd          (rst_cmd),
        .st               (st),
        .op_l             (op_l),
        .d7_l             (d7_l),
        .sel_l            (sel_l),
        .accept           (accept),
        .susp             (susp)
    );

    flst_sect_hit #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS)
    ) u_hit (
        .rd_addr (rd_addr),
        .sel     (sel_l),
        .hit     (hit)
    );

    flst_toggle u_tog (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_ce_n     (rd_ce_n),
        .rd_oe_n     (rd_oe_n),
        .status_mode (status_mode),
        .accept      (accept),
        .susp        (susp),
        .hit         (hit),
        .rd_act      (rd_act),
        .rd_start    (rd_start),
        .tog6        (tog6),
        .tog2        (tog2)
    );

    assign status_mode = (st != ST_ARRAY);
    assign is_prog     = (op_l == OP_PROG);

    // Assemble the status byte from phase, context and toggles.
    always_comb begin
        word    = 8'h00;
        word[7] = susp ? 1'b1 : (is_prog ? ~d7_l : 1'b0);
        word[6] = tog6;
        word[5] = (st == ST_FAIL);
        word[3] = !is_prog && (st != ST_ARM);
        word[2] = tog2;
    end

    assign status_drive = status_mode && rd_act;
    assign status_q     = status_drive ? word : 8'h00;
endmodule

// File: rtl/flst_status_gen_chk.sv
// Property checker for the status generator, bound into the top module.
module flst_status_gen_chk
    import flst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] st,
    input logic       susp,
    input logic       rd_start,
    input logic       hit,
    input logic       accept,
    input logic       tog2,
    input logic       rst_cmd,
    input logic       status_drive,
    input logic [7:0] status_q
);
    // R2: bit 6 holds while a read stays active with no new read start.
    p_dq6_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_drive) && status_drive && !$past(rd_start) && !$past(accept))
        |-> $stable(status_q[6]));

    // R3: bit 6 frozen across reads while suspended.
    p_dq6_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(susp) && $past(status_drive) && status_drive)
        |-> $stable(status_q[6]));

    // R4: bit 2 does not change on reads outside the selected sectors.
    p_dq2_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_start) && !$past(hit) && !$past(accept))
        |-> $stable(tog2));

    // R6: the erase-start window only exits into the running phase.
    p_arm_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st == ST_ARM) && st != ST_ARM) |-> (st == ST_ALGO));

    // R7: the protected-sector window only exits to array mode.
    p_prot_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st == ST_PROT) && st != ST_PROT) |-> (st == ST_ARRAY));

    // R8: failure persists until read/reset.
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st == ST_FAIL) && !$past(rst_cmd)) |-> (st == ST_FAIL));

    // R10: unused status positions never read 1.
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[4] == 1'b0 && status_q[1:0] == 2'b00));
endmodule

bind flst_status_gen flst_status_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .susp         (susp),
    .rd_start     (rd_start),
    .hit          (hit),
    .accept       (accept),
    .tog2         (tog2),
    .rst_cmd      (rst_cmd),
    .status_drive (status_drive),
    .status_q     (status_q)
);

// File: tb/flst_status_gen_bench.sv
module flst_status_gen_bench;
    localparam int AW = 6;
    localparam int SB = 2;
    localparam int NS = 4;
    localparam int CPU = 2;
    localparam int PU = 3;
    localparam int AU = 2;
    localparam int PW = 4;
    localparam int PROT_CYC = PU * CPU;
    localparam int ARM_CYC = AU * CPU;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_go = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          prog_d7 = 1'b0;
    logic          prog_zero_to_one = 1'b0;
    logic [NS-1:0] sect_sel = '0;
    logic [NS-1:0] sect_prot = '0;
    logic          pulse_tick = 1'b0;
    logic [PW-1:0] pulse_limit = 4'd15;
    logic          alg_done = 1'b0;
    logic          erase_susp = 1'b0;
    logic          rst_cmd = 1'b0;
    logic          rd_ce_n = 1'b1;
    logic          rd_oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          status_drive;
    logic [7:0]    status_q;

    int n_chk = 0;
    int n_fail = 0;
    bit e6, e2, m_susp, m_arm, m_fail, m_d7;
    logic [1:0]    m_op;
    logic [NS-1:0] m_sel;

    flst_status_gen #(
        .ADDR_W(AW), .SECT_BITS(SB), .CYC_PER_US(CPU),
        .PROT_US(PU), .ARM_US(AU), .PCNT_W(PW)
    ) u_flst_status_gen (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .prog_d7(prog_d7), .prog_zero_to_one(prog_zero_to_one),
        .sect_sel(sect_sel), .sect_prot(sect_prot), .pulse_tick(pulse_tick),
        .pulse_limit(pulse_limit), .alg_done(alg_done), .erase_susp(erase_susp),
        .rst_cmd(rst_cmd), .rd_ce_n(rd_ce_n), .rd_oe_n(rd_oe_n),
        .rd_addr(rd_addr), .status_drive(status_drive), .status_q(status_q)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_word();
        logic [7:0] w;
        w = 8'h00;
        w[7] = m_susp ? 1'b1 : ((m_op == 2'd0) ? ~m_d7 : 1'b0);
        w[6] = e6;
        w[5] = m_fail;
        w[3] = (m_op != 2'd0) && !m_arm;
        w[2] = e2;
        return w;
    endfunction

    task automatic go(input logic [1:0] op, input logic [NS-1:0] sel,
                      input logic d7, input logic bad);
        cmd_op = op; sect_sel = sel; prog_d7 = d7; prog_zero_to_one = bad;
        cmd_go = 1'b1;
        tick(1);
        cmd_go = 1'b0; prog_zero_to_one = 1'b0;
        e6 = 0; e2 = 0; m_op = op; m_d7 = d7; m_susp = 0; m_fail = bad;
        m_arm = (op == 2'd1);
        m_sel = (op == 2'd2) ? '1 : ((op == 2'd0) ? '0 : sel);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        rd_addr = a; rd_ce_n = 1'b0; rd_oe_n = 1'b0;
        tick(1);
        if (!m_susp) e6 = ~e6;
        if (m_sel[a[AW-1 -: SB]]) e2 = ~e2;
        chk({tag, " drive"}, 32'(status_drive), 32'd1);
        chk({tag, " word"}, 32'(status_q), 32'(exp_word()));
        rd_ce_n = 1'b1; rd_oe_n = 1'b1;
        tick(1);
    endtask

    task automatic rd_idle(input logic [AW-1:0] a, input string tag);
        rd_addr = a; rd_oe_n = 1'b0; rd_ce_n = 1'b0;
        tick(1);
        chk({tag, " drive"}, 32'(status_drive), 32'd0);
        chk({tag, " word"}, 32'(status_q), 32'd0);
        rd_ce_n = 1'b1; rd_oe_n = 1'b1;
        tick(1);
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            pulse_tick = 1'b1; tick(1); pulse_tick = 1'b0; tick(1);
        end
    endtask

    task automatic done_pulse();
        alg_done = 1'b1; tick(1); alg_done = 1'b0; tick(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: run hung, got 0 expected 1");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] held;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state and array-mode reads
        chk("R1 reset drive", 32'(status_drive), 32'd0);
        chk("R1 reset word", 32'(status_q), 32'd0);
        rd_idle(6'h05, "R1 idle read");

        // R5/R2: program, data bit 1 and 0
        for (int d = 0; d < 2; d++) begin
            go(2'd0, '0, d[0], 1'b0);
            for (int k = 0; k < 4; k++) rd(6'(k * 16), "R2 R5 R4 program poll");
            // R2: hold read low; bit 6 must not change
            rd_ce_n = 1'b0; rd_oe_n = 1'b0; tick(1); held = status_q;
            tick(3);
            chk("R2 hold bit6", 32'(status_q[6]), 32'(held[6]));
            rd_ce_n = 1'b1; rd_oe_n = 1'b1; tick(1);
            e6 = ~e6;
            // R11: reset command ignored while running
            rst_cmd = 1'b1; tick(1); rst_cmd = 1'b0; tick(1);
            rd(6'h00, "R11 rst ignored running");
            done_pulse();
            rd_idle(6'h00, "R5 done returns array");
        end

        // R9: zero-to-one program fails at once
        go(2'd0, '0, 1'b0, 1'b1);
        rd(6'h10, "R9 zero-to-one fail");
        done_pulse();
        rd(6'h10, "R8 done ignored in fail");
        rst_cmd = 1'b1; tick(1); rst_cmd = 1'b0; tick(1);
        rd_idle(6'h10, "R11 rst from fail");

        // R8: pulse limit sweep
        for (int lim = 1; lim <= 4; lim++) begin
            pulse_limit = PW'(lim);
            go(2'd0, '0, 1'b1, 1'b0);
            pulse(lim - 1);
            rd(6'h20, "R8 R10 below limit");
            pulse(1);
            m_fail = 1;
            rd(6'h20, "R8 at limit");
            rst_cmd = 1'b1; tick(1); rst_cmd = 1'b0; tick(1);
            rd_idle(6'h20, "R11 after limit");
        end
        pulse_limit = 4'd15;

        // R6/R4/R3: sector erase over all selection maps
        for (int s = 1; s < 16; s++) begin
            sect_prot = '0;
            go(2'd1, 4'(s), 1'b0, 1'b0);
            tick(ARM_CYC - 3);
            rd(6'h10, "R6 before window end");
            m_arm = 0;
            rd(6'h10, "R6 after window end");
            for (int sec = 0; sec < NS; sec++) rd(6'(sec * 16 + 3), "R4 erase sweep");
            erase_susp = 1'b1; m_susp = 1;
            for (int sec = 0; sec < NS; sec++) rd(6'(sec * 16), "R3 R4 suspended sweep");
            pulse(3);
            done_pulse();
            rd(6'h00, "R3 done ignored in suspend");
            erase_susp = 1'b0; m_susp = 0;
            rd(6'h30, "R3 resumed");
            done_pulse();
            rd_idle(6'h30, "R5 erase done");
        end

        // R6: chip erase with partial protection
        sect_prot = 4'b0110;
        go(2'd2, '0, 1'b0, 1'b0);
        for (int sec = 0; sec < NS; sec++) rd(6'(sec * 16 + 1), "R6 R4 chip erase");
        done_pulse();
        rd_idle(6'h00, "R5 chip done");

        // R7: all selected sectors protected
        sect_prot = 4'b0010;
        go(2'd1, 4'b0010, 1'b0, 1'b0);
        m_arm = 0;
        tick(PROT_CYC - 2);
        rd(6'h10, "R7 window open");
        rd_idle(6'h10, "R7 window closed");
        sect_prot = 4'b1111;
        go(2'd2, '0, 1'b0, 1'b0);
        tick(PROT_CYC - 2);
        rd(6'h00, "R7 chip window open");
        rd_idle(6'h00, "R7 chip window closed");

        // R5: no-command code is ignored
        sect_prot = '0;
        cmd_op = 2'd3; cmd_go = 1'b1; tick(1); cmd_go = 1'b0; tick(1);
        rd_idle(6'h00, "R5 op3 ignored");

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule